// File: doc/BRIEF.md
# Double-Precision Aligned Add/Subtract Datapath

This block is the front half of a double-precision floating-point adder. It accepts two 64-bit binary64 operands and a 3-bit operation code. It splits each operand into sign, biased exponent and significand, restoring the hidden one. It picks the operand with the larger exponent and shifts the other significand right until the binary points line up. It then forms the sum or the difference of the magnitudes and renormalises the result. The result is held in an output register for a separate rounding stage.

The hand-off is an unrounded triple: a sign, a 12-bit exponent term and a 56-bit significand term. The significand term carries two remainder bits below the fraction. Shifted-out bits below those two positions are discarded, so the datapath on its own truncates toward zero. An operand whose exponent field is zero is taken as zero. Infinities, NaNs and rounding are handled further downstream. Exponent 2047 is treated as an ordinary exponent here.

Operands are captured when both `en_i` and `valid_i` are high at a rising clock edge. `ready_o` marks the held result one cycle later.

Top module: `fp_addsub_core`

## Requirements
- R1: An operand whose 11-bit exponent field is zero contributes zero, whatever its fraction bits; a nonzero exponent implies a leading one above the 52 fraction bits.
- R2: Operation code 3'b000 computes A + B and 3'b001 computes A − B; every other code computes A + B.
- R3: Operands are ordered by exponent alone. The significand of the operand with the smaller exponent is shifted right by the exponent difference, with no shift when the exponents are equal. Bits shifted below the two remainder positions are dropped, so a difference of 56 or more makes that operand vanish.
- R4: When the effective signs differ, the smaller magnitude is taken from the larger. The result sign is that of the larger-magnitude operand, so A − B with |A| < |B| yields the inverted sign.
- R5: A nonzero result has mantissa term bit 55 = 0 and bit 54 = 1, with the fraction in bits 53..2 and the two remainder bits in bits 1..0.
- R6: When a magnitude sum carries into bit 55, the term is shifted right by one and the exponent term is incremented. Because the exponent term is 12 bits wide, 2047 + 1 reads as 12'h800.
- R7: After a magnitude difference, the term is shifted left until bit 54 is one, and the exponent term is reduced by the shift amount. If the shift is at least the larger exponent, the exponent term becomes 0.
- R8: An exact zero result gives sign 0, exponent term 0 and mantissa term 0.
- R9: The result register loads only at a rising edge where `en_i` and `valid_i` are both high, and holds its value otherwise.
- R10: `ready_o` is high for the cycle that follows the load cycle. It is low if `en_i` is low at that next edge, and it is low during the load cycle itself.
- R11: While `rst_ni` is low, `ready_o`, `sign_o`, `exp_o` and `mant_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; gates loading and `ready_o` |
| valid_i | input | 1 | Operands and code are present |
| op_i | input | 3 | Operation code (000 add, 001 subtract) |
| opa_i | input | 64 | Operand A, binary64 |
| opb_i | input | 64 | Operand B, binary64 |
| sign_o | output | 1 | Result sign |
| exp_o | output | 12 | Result exponent term, leading guard bit |
| mant_o | output | 56 | Result significand term with two remainder bits |
| ready_o | output | 1 | Held result is ready for the rounding stage |

## Verification
The bench builds the block with its default widths, an 11-bit exponent and a 52-bit fraction. At these widths the real binary64 encodings of 1.0, 1.5 and 2.0 can be used as directed cases. The same widths expose the exact boundaries at which a difference of 53 leaves one remainder bit set and a difference of 60 removes the operand entirely. They also give the 2047 exponent that carries into the twelfth bit, and the smallest normal exponent at which a cancellation clamps to zero. Random operands keep the exponent difference within about 60, so that alignment, cancellation and the carry path are hit often, and the bench mixes in zero-exponent operands and unused operation codes.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001
  } fp_op_e;

  // Any code other than subtract behaves as add
  function automatic logic op_is_sub(input logic [2:0] code);
    return code == OP_SUB;
  endfunction

endpackage

// File: rtl/fp_unpack.sv
module fp_unpack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  input  logic                  flip_i,
  output logic                  sign_o,
  output logic [EXP_W:0]        exp_o,
  output logic [FRAC_W+3:0]     term_o
);
  logic [EXP_W-1:0] bexp;
  logic             is_zero;

  assign bexp    = val_i[EXP_W+FRAC_W-1:FRAC_W];
  assign is_zero = (bexp == '0);
  assign sign_o  = val_i[EXP_W+FRAC_W] ^ flip_i;
  assign exp_o   = {1'b0, bexp};
  // zero-exponent encodings collapse to zero
  assign term_o  = is_zero ? '0 : {2'b01, val_i[FRAC_W-1:0], 2'b00};
endmodule

// File: rtl/fp_align.sv
module fp_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic              sa_i,
  input  logic [EXP_W:0]    ea_i,
  input  logic [FRAC_W+3:0] ma_i,
  input  logic              sb_i,
  input  logic [EXP_W:0]    eb_i,
  input  logic [FRAC_W+3:0] mb_i,
  output logic              sx_o,
  output logic [EXP_W:0]    ex_o,
  output logic [FRAC_W+3:0] mx_o,
  output logic              sy_o,
  output logic [FRAC_W+3:0] my_o
);
  localparam int TERM_W = FRAC_W + 4;
  localparam int EXPT_W = EXP_W + 1;

  logic              a_big;
  logic [EXPT_W-1:0] diff;
  logic [TERM_W-1:0] my_raw;

  // exponent-only ordering; ties put B in the large slot
  assign a_big  = ea_i > eb_i;
  assign sx_o   = a_big ? sa_i : sb_i;
  assign ex_o   = a_big ? ea_i : eb_i;
  assign mx_o   = a_big ? ma_i : mb_i;
  assign sy_o   = a_big ? sb_i : sa_i;
  assign my_raw = a_big ? mb_i : ma_i;
  assign diff   = a_big ? (ea_i - eb_i) : (eb_i - ea_i);

  always_comb begin
    if (diff >= EXPT_W'(TERM_W)) my_o = '0;
    else                         my_o = my_raw >> diff;
  end
endmodule

// File: rtl/fp_combine.sv
module fp_combine #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic              sx_i,
  input  logic [EXP_W:0]    ex_i,
  input  logic [FRAC_W+3:0] mx_i,
  input  logic              sy_i,
  input  logic [FRAC_W+3:0] my_i,
  output logic              sign_o,
  output logic [EXP_W:0]    exp_o,
  output logic [FRAC_W+3:0] mant_o
);
  localparam int TERM_W = FRAC_W + 4;
  localparam int EXPT_W = EXP_W + 1;
  localparam int LZ_W   = $clog2(TERM_W);

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [TERM_W-2:0] v);
    logic [LZ_W-1:0] n;
    n = '0;
    for (int i = 0; i < TERM_W - 1; i++)
      if (v[i]) n = LZ_W'(TERM_W - 2 - i);
    return n;
  endfunction

  logic              eff_sub;
  logic              raw_sign;
  logic [TERM_W-1:0] raw;
  logic [LZ_W-1:0]   lz;
  logic [EXPT_W-1:0] lz_ext;

  assign eff_sub = sx_i ^ sy_i;

  always_comb begin
    if (!eff_sub) begin
      raw      = mx_i + my_i;
      raw_sign = sx_i;
    end else if (mx_i >= my_i) begin
      raw      = mx_i - my_i;
      raw_sign = sx_i;
    end else begin
      raw      = my_i - mx_i;
      raw_sign = sy_i;
    end
  end

  assign lz     = lead_zeros(raw[TERM_W-2:0]);
  assign lz_ext = EXPT_W'(lz);

  always_comb begin
    if (raw == '0) begin
      sign_o = 1'b0;
      exp_o  = '0;
      mant_o = '0;
    end else if (raw[TERM_W-1]) begin
      sign_o = raw_sign;
      exp_o  = ex_i + EXPT_W'(1);
      mant_o = raw >> 1;
    end else begin
      sign_o = raw_sign;
      exp_o  = (lz_ext >= ex_i) ? '0 : (ex_i - lz_ext);
      mant_o = raw << lz;
    end
  end
endmodule

// File: rtl/fp_addsub_core.sv
module fp_addsub_core #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  valid_i,
  input  logic [2:0]            op_i,
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  output logic                  sign_o,
  output logic [EXP_W:0]        exp_o,
  output logic [FRAC_W+3:0]     mant_o,
  output logic                  ready_o
);
  import fp_addsub_pkg::*;

  localparam int TERM_W = FRAC_W + 4;
  localparam int EXPT_W = EXP_W + 1;

  logic              is_sub;
  logic              s_op  [2];
  logic [EXPT_W-1:0] e_op  [2];
  logic [TERM_W-1:0] m_op  [2];
  logic [EXP_W+FRAC_W:0] v_op [2];
  logic              f_op  [2];

  assign is_sub  = op_is_sub(op_i);
  assign v_op[0] = opa_i;
  assign v_op[1] = opb_i;
  assign f_op[0] = 1'b0;
  assign f_op[1] = is_sub;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .val_i (v_op[g]),
      .flip_i(f_op[g]),
      .sign_o(s_op[g]),
      .exp_o (e_op[g]),
      .term_o(m_op[g])
    );
  end

  logic              sx, sy;
  logic [EXPT_W-1:0] ex;
  logic [TERM_W-1:0] mx, my;

  fp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sa_i(s_op[0]), .ea_i(e_op[0]), .ma_i(m_op[0]),
    .sb_i(s_op[1]), .eb_i(e_op[1]), .mb_i(m_op[1]),
    .sx_o(sx), .ex_o(ex), .mx_o(mx),
    .sy_o(sy), .my_o(my)
  );

  logic              res_sign;
  logic [EXPT_W-1:0] res_exp;
  logic [TERM_W-1:0] res_mant;

  fp_combine #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_combine (
    .sx_i(sx), .ex_i(ex), .mx_i(mx),
    .sy_i(sy), .my_i(my),
    .sign_o(res_sign), .exp_o(res_exp), .mant_o(res_mant)
  );

  logic load, vld_q, rdy_q;
  assign load = en_i & valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      rdy_q  <= 1'b0;
      sign_o <= 1'b0;
      exp_o  <= '0;
      mant_o <= '0;
    end else begin
      vld_q <= load;
      rdy_q <= en_i & vld_q;
      if (load) begin
        sign_o <= res_sign;
        exp_o  <= res_exp;
        mant_o <= res_mant;
      end
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              valid_i,
  input logic              sign_o,
  input logic [EXP_W:0]    exp_o,
  input logic [FRAC_W+3:0] mant_o,
  input logic              ready_o
);
  localparam int TERM_W = FRAC_W + 4;

  assert_carry_bit_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mant_o[TERM_W-1]);

  assert_normalised_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && mant_o != '0) |-> mant_o[TERM_W-2]);

  assert_zero_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && mant_o == '0) |-> (exp_o == '0 && !sign_o));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && valid_i) |=> ($stable(mant_o) && $stable(exp_o) && $stable(sign_o)));

  assert_ready_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ready_o);

  assert_ready_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(en_i && valid_i, 2));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R11: assert (!ready_o && mant_o == '0 && exp_o == '0 && !sign_o);
    end
  end
endmodule

bind fp_addsub_core fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .valid_i(valid_i),
  .sign_o (sign_o),
  .exp_o  (exp_o),
  .mant_o (mant_o),
  .ready_o(ready_o)
);

// File: tb/tb_fp_addsub_core.sv
`timescale 1ns/1ps
module tb_fp_addsub_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        sign_o;
  logic [11:0] exp_o;
  logic [55:0] mant_o;
  logic        ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] ONEH = 64'h3FF8000000000000;
  localparam logic [55:0] LEAD = 56'h40000000000000;

  always #4 clk_i = ~clk_i;

  fp_addsub_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .sign_o(sign_o), .exp_o(exp_o), .mant_o(mant_o), .ready_o(ready_o)
  );

  function automatic logic [68:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [2:0] op);
    logic        s1, s2, sr;
    logic [11:0] e1, e2, er;
    logic [55:0] t1, t2, r;
    int          d;
    s1 = a[63];
    s2 = b[63] ^ (op == 3'b001);
    e1 = {1'b0, a[62:52]};
    e2 = {1'b0, b[62:52]};
    t1 = (e1 == 0) ? 56'd0 : {2'b01, a[51:0], 2'b00};
    t2 = (e2 == 0) ? 56'd0 : {2'b01, b[51:0], 2'b00};
    if (e1 > e2) begin
      d = int'(e1) - int'(e2); er = e1;
      t2 = (d > 55) ? 56'd0 : (t2 >> d);
    end else begin
      d = int'(e2) - int'(e1); er = e2;
      t1 = (d > 55) ? 56'd0 : (t1 >> d);
    end
    if (s1 == s2) begin r = t1 + t2; sr = s1; end
    else if (t1 >= t2) begin r = t1 - t2; sr = s1; end
    else begin r = t2 - t1; sr = s2; end
    if (r == 0) return 69'd0;
    if (r[55]) begin r = r >> 1; er = er + 12'd1; end
    while (!r[54]) begin
      r = r << 1;
      er = (er > 0) ? er - 12'd1 : 12'd0;
    end
    return {sr, er, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [68:0] act,
                     input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [68:0] outs();
    return {sign_o, exp_o, mant_o};
  endfunction

  // one transaction: load edge, then ready edge
  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [2:0] op,
                     input string req, input logic [68:0] exp);
    @(negedge clk_i);
    opa_i = a; opb_i = b; op_i = op; valid_i = 1'b1; en_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(ready_o == 1'b0, "R10 ready low in load cycle", 69'(ready_o), 69'd0);
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R10 ready after load", 69'(ready_o), 69'd1);
    chk(outs() == exp, req, outs(), exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [68:0] held;
    void'($urandom(32'd7321));
    #3;
    chk(outs() == 69'd0 && ready_o == 1'b0, "R11 reset state", {outs()}, 69'd0);
    #20;
    rst_ni = 1'b1;

    run(ONE, ONE, 3'b000, "R6 1+1 carry", {1'b0, 12'h400, LEAD});
    run(ONE, ONE, 3'b001, "R8 1-1 zero", 69'd0);
    run(ONE, TWO, 3'b001, "R4 1-2 sign inverted", {1'b1, 12'h3FF, LEAD});
    run(TWO, ONE, 3'b001, "R7 2-1 left shift", {1'b0, 12'h3FF, LEAD});
    run(ONEH, ONE, 3'b001, "R4 equal exp 1.5-1", {1'b0, 12'h3FE, LEAD});
    run(ONE, ONEH, 3'b001, "R4 equal exp 1-1.5", {1'b1, 12'h3FE, LEAD});
    run(ONE, 64'h3CA0000000000000, 3'b000, "R3 diff 53 remainder", {1'b0, 12'h3FF, LEAD | 56'd2});
    run(ONE, 64'h3C30000000000000, 3'b000, "R3 diff 60 dropped", {1'b0, 12'h3FF, LEAD});
    run(64'h0000000000000001, ONE, 3'b000, "R1 zero exponent operand", {1'b0, 12'h3FF, LEAD});
    run(64'h7FF0000000000000, 64'h7FF0000000000000, 3'b000, "R6 exponent guard bit",
        {1'b0, 12'h800, LEAD});
    run(64'h0010000000000001, 64'h0010000000000000, 3'b001, "R7 exponent clamp",
        {1'b0, 12'h000, LEAD});
    run(ONE, ONE, 3'b110, "R2 unused code adds", {1'b0, 12'h400, LEAD});
    run(64'hBFF0000000000000, 64'hBFF0000000000000, 3'b000, "R5 negative sum",
        {1'b1, 12'h400, LEAD});

    // R9: no load while enable low
    held = outs();
    @(negedge clk_i);
    opa_i = TWO; opb_i = TWO; op_i = 3'b000; valid_i = 1'b1; en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(outs() == held, "R9 hold when enable low", outs(), held);
    chk(ready_o == 1'b0, "R10 ready low when enable low", 69'(ready_o), 69'd0);

    // R10: enable drops right after the load edge
    @(negedge clk_i);
    en_i = 1'b1; valid_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0; valid_i = 1'b0;
    @(negedge clk_i);
    chk(ready_o == 1'b0, "R10 ready gated by enable", 69'(ready_o), 69'd0);
    chk(outs() == {1'b0, 12'h401, LEAD}, "R9 loaded 2+2", outs(), {1'b0, 12'h401, LEAD});

    for (int n = 0; n < 500; n++) begin
      logic [63:0] a, b;
      logic [2:0]  op;
      int          ea, eb;
      ea = 1 + int'($urandom % 2046);
      eb = ea + int'($urandom % 121) - 60;
      if (eb < 0) eb = 0;
      if (eb > 2047) eb = 2047;
      if ($urandom % 16 == 0) eb = 0;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      a[62:52] = 11'(ea);
      b[62:52] = 11'(eb);
      if ($urandom % 8 == 0) b[51:0] = a[51:0];
      op = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      run(a, b, op, "R3 R4 R5 R7 random", model(a, b, op));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule